// File: doc/BRIEF.md
# Pseudo-Random Serial Link Error Counter

This block exercises a serial link one bit per clock. A linear feedback shift register produces a pseudo-random stream of order 8, 16 or 24, which leaves on `tx_bit`. The far end loops the stream back, and it returns on `rx_bit` after some link latency. Inside the block, the transmitted bits pass through a tapped shift register. The tap is chosen in whole clock periods so that the reference bit lines up with the returning bit. Each aligned pair is compared. A wide bit counter and a saturating error counter accumulate the result, and a lock flag reports a run of clean compares. At the intended 160 MHz bit clock, the 48-bit bit counter covers far more than 10^13 bits.

Alignment finer than one clock is done outside the block. A fine delay code, where one step is about 75 ps, is registered and presented on `fine_tap` for an external programmable delay element. The fine code never alters the comparison.

Top module: `ber_tester`

## Requirements
- R1: `ord_sel` picks the pattern: 2'b00 gives x^8+x^6+x^5+x^4+1, 2'b01 gives x^16+x^14+x^13+x^11+1, and 2'b10 or 2'b11 give x^24+x^23+x^22+x^17+1. The register starts at all ones. Each running cycle it shifts left, and bit 0 takes the XOR of bits (7,5,4,3), (15,13,12,10) or (23,22,21,16). `tx_bit` is bit 7, 15 or 23. The seed's top bit appears in the first cycle after `run` is first sampled high.
- R2: While not running, `tx_bit` is 0 and both counters hold.
- R3: The reference bit is the transmitted bit delayed by exactly `coarse_sel` clocks (0 to 31). A loopback with that same latency produces no errors.
- R4: Each running clock edge that is not a clear is one compare. It adds 1 to `bit_cnt`, and adds 1 to `err_cnt` only when `rx_bit` differs from the reference. The result is visible after that edge.
- R5: `err_cnt` (ERR_W bits, 32 by default) saturates at all ones.
- R6: `clr` high at an edge zeroes both counters and the lock. The compare at that edge is not counted.
- R7: Changing `coarse_sel` while running clears the counters and the lock at that edge.
- R8: Changing `ord_sel` while running reseeds the generator with all ones and clears the counters and the lock at that edge.
- R9: `locked` rises after 64 consecutive error-free compares. It falls at the edge of any erroring compare.
- R10: `fine_tap` equals `fine_sel` one clock later and has no effect on counting.
- R11: Starting (`run` sampled high while stopped) clears both counters. `bit_cnt` is 48 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bit clock |
| rst_n | input | 1 | synchronous active-low reset |
| run | input | 1 | run level, high to generate and compare |
| clr | input | 1 | counter clear request |
| ord_sel | input | 2 | pattern order select |
| coarse_sel | input | 5 | reference delay in clock periods |
| fine_sel | input | 6 | fine delay code, about 75 ps per step |
| rx_bit | input | 1 | looped-back serial input |
| tx_bit | output | 1 | serial pattern output |
| fine_tap | output | 6 | registered tap code for the external delay |
| bit_cnt | output | 48 | compared bit count |
| err_cnt | output | 32 | mismatch count, saturating |
| locked | output | 1 | clean-run flag |

## Verification
A corrupted generator state shows up in the first clock, because `tx_bit` departs from the independently modelled sequence. A wrong delay tap makes `err_cnt` start climbing within a few compares and keeps `locked` low. Counter or clear faults appear as a count that is off at the very next edge after a start, clear, delay change or order change. A fault in the lock counter makes `locked` rise one compare early or late around compare 64.

// File: rtl/ber_pkg.sv
// Shared types and helpers for the serial link error counter.
package ber_pkg;
    localparam int LFSR_W = 24;

    typedef enum logic [1:0] {
        ORD_8   = 2'b00,
        ORD_16  = 2'b01,
        ORD_24  = 2'b10,
        ORD_24B = 2'b11
    } ord_e;

    // Feedback tap mask for the selected order.
    function automatic logic [LFSR_W-1:0] tap_mask(ord_e o);
        case (o)
            ORD_8:   return 24'h0000B8;
            ORD_16:  return 24'h00B400;
            default: return 24'hE10000;
        endcase
    endfunction

    // Index of the register bit that leaves the block.
    function automatic logic [4:0] out_idx(ord_e o);
        case (o)
            ORD_8:   return 5'd7;
            ORD_16:  return 5'd15;
            default: return 5'd23;
        endcase
    endfunction
endpackage

// File: rtl/ber_prbs_gen.sv
// Pattern generator: Fibonacci shift register, shift left, feedback into bit 0.
// Assumes order is stable except on cycles where reseed is raised.
module ber_prbs_gen
    import ber_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic reseed,
    input  ord_e ord,
    output logic bit_o
);
    logic [LFSR_W-1:0] lfsr;
    logic              fb;

    // Feedback bit from the taps of the active order.
    always_comb fb = ^(lfsr & tap_mask(ord));

    // Register update: seed, shift, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      lfsr <= '1;
        else if (reseed) lfsr <= '1;
        else if (en)     lfsr <= {lfsr[LFSR_W-2:0], fb};
    end

    // Serial output, quiet while idle.
    always_comb bit_o = en ? lfsr[out_idx(ord)] : 1'b0;
endmodule

// File: rtl/ber_coarse_dly.sv
// Reference delay line: taps the transmitted stream 0..DEPTH-1 clocks back.
// Shifts every cycle so the history is always consistent with the sent bits.
module ber_coarse_dly #(
    parameter  int DEPTH = 32,
    localparam int SW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [SW-1:0] sel,
    output logic          dout
);
    logic [DEPTH-2:0] sr;
    logic [DEPTH-1:0] taps;

    // History of sent bits, newest in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-3:0], din};
    end

    // Tap select: zero delay picks the live bit.
    always_comb begin
        taps = {sr, din};
        dout = taps[sel];
    end
endmodule

// File: rtl/ber_tally.sv
// Compare accounting: bit counter, saturating error counter, clean-run lock.
// Assumes clr and en are never both acted on; clr wins.
module ber_tally #(
    parameter  int BIT_W    = 48,
    parameter  int ERR_W    = 32,
    parameter  int LOCK_LEN = 64,
    localparam int LK_W     = $clog2(LOCK_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             mismatch,
    output logic [BIT_W-1:0] bit_cnt,
    output logic [ERR_W-1:0] err_cnt,
    output logic             locked
);
    localparam logic [LK_W-1:0] LK_MAX = LK_W'(LOCK_LEN);
    logic [LK_W-1:0] clean;

    // Bit counter: one per compare.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bit_cnt <= '0;
        else if (en)       bit_cnt <= bit_cnt + 1'b1;
    end

    // Error counter: one per mismatch, held at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                     err_cnt <= '0;
        else if (en && mismatch && ~&err_cnt)  err_cnt <= err_cnt + 1'b1;
    end

    // Clean-run length, saturating at the lock threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       clean <= '0;
        else if (en) begin
            if (mismatch)        clean <= '0;
            else if (clean != LK_MAX) clean <= clean + 1'b1;
        end
    end

    // Lock is a full clean window.
    always_comb locked = (clean == LK_MAX);
endmodule

// File: rtl/ber_tester.sv
// Top: generator, reference delay, compare and accounting, fine tap register.
// Assumes rx_bit is synchronous to clk (sampled by the external delay stage).
module ber_tester
    import ber_pkg::*;
#(
    parameter  int BIT_W     = 48,
    parameter  int ERR_W     = 32,
    parameter  int DLY_DEPTH = 32,
    parameter  int FINE_W    = 6,
    parameter  int LOCK_LEN  = 64,
    localparam int DLY_SW    = $clog2(DLY_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [1:0]        ord_sel,
    input  logic [DLY_SW-1:0] coarse_sel,
    input  logic [FINE_W-1:0] fine_sel,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic [FINE_W-1:0] fine_tap,
    output logic [BIT_W-1:0]  bit_cnt,
    output logic [ERR_W-1:0]  err_cnt,
    output logic              locked
);
    logic              act;
    ord_e              ord_q;
    logic [DLY_SW-1:0] coarse_q;
    logic              start, ord_chg, crs_chg, clr_all, cmp_en, ref_bit, mismatch;

    // Run state and last-seen settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            ord_q    <= ORD_8;
            coarse_q <= '0;
            fine_tap <= '0;
        end else begin
            act      <= run;
            ord_q    <= ord_e'(ord_sel);
            coarse_q <= coarse_sel;
            fine_tap <= fine_sel;
        end
    end

    // Events that restart the measurement.
    always_comb begin
        start    = run & ~act;
        ord_chg  = run & act & (ord_e'(ord_sel) != ord_q);
        crs_chg  = act & (coarse_sel != coarse_q);
        clr_all  = clr | start | ord_chg | crs_chg;
        cmp_en   = act & ~clr_all;
        mismatch = rx_bit ^ ref_bit;
    end

    ber_prbs_gen u_gen (
        .clk(clk), .rst_n(rst_n), .en(act), .reseed(start | ord_chg),
        .ord(ord_q), .bit_o(tx_bit)
    );

    ber_coarse_dly #(.DEPTH(DLY_DEPTH)) u_dly (
        .clk(clk), .rst_n(rst_n), .din(tx_bit), .sel(coarse_sel), .dout(ref_bit)
    );

    ber_tally #(.BIT_W(BIT_W), .ERR_W(ERR_W), .LOCK_LEN(LOCK_LEN)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(cmp_en), .mismatch(mismatch),
        .bit_cnt(bit_cnt), .err_cnt(err_cnt), .locked(locked)
    );
endmodule

// File: rtl/ber_tester_chk.sv
// Property checker for ber_tester, bound to every instance.
module ber_tester_chk #(
    parameter int BIT_W  = 48,
    parameter int ERR_W  = 32,
    parameter int FINE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              tx_bit,
    input logic [FINE_W-1:0] fine_sel,
    input logic [FINE_W-1:0] fine_tap,
    input logic [BIT_W-1:0]  bit_cnt,
    input logic [ERR_W-1:0]  err_cnt,
    input logic              locked,
    input logic              clr_all,
    input logic              cmp_en,
    input logic              mismatch
);
    logic seen;

    // Marks that one clean post-reset edge has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (tx_bit == 1'b0)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) cmp_en |=> bit_cnt == $past(bit_cnt) + 1'b1); // R4
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cmp_en && !mismatch) |=> $stable(err_cnt)); // R4
    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) {{(BIT_W-ERR_W){1'b0}}, err_cnt} <= bit_cnt); // R4
    AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n) (&err_cnt && !clr_all) |=> &err_cnt); // R5
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_all |=> (bit_cnt == '0 && err_cnt == '0 && !locked)); // R6
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (cmp_en && mismatch) |=> !locked); // R9
    AST_FINE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) seen |-> fine_tap == $past(fine_sel)); // R10
endmodule

bind ber_tester ber_tester_chk #(.BIT_W(BIT_W), .ERR_W(ERR_W), .FINE_W(FINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tx_bit(tx_bit), .fine_sel(fine_sel),
    .fine_tap(fine_tap), .bit_cnt(bit_cnt), .err_cnt(err_cnt), .locked(locked),
    .clr_all(clr_all), .cmp_en(cmp_en), .mismatch(mismatch)
);

// File: tb/sim_ber_tester.sv
module sim_ber_tester;
    localparam int CLK_P = 10;
    localparam int EW    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, clr = 1'b0, inj = 1'b0;
    logic [1:0]  ord_sel = 2'b00;
    logic [4:0]  coarse_sel = 5'd0;
    logic [5:0]  fine_sel = 6'd0;
    int          d = 0;
    logic        rx_bit, tx_bit, locked;
    logic [5:0]  fine_tap;
    logic [47:0] bit_cnt;
    logic [EW-1:0] err_cnt;
    logic [30:0] bsr = '0;
    logic [31:0] btaps;
    int          total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    // Loopback with a latency of d clocks, plus error injection.
    always @(posedge clk) bsr <= {bsr[29:0], tx_bit};
    assign btaps  = {bsr, tx_bit};
    assign rx_bit = btaps[d] ^ inj;

    ber_tester #(.ERR_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .ord_sel(ord_sel),
        .coarse_sel(coarse_sel), .fine_sel(fine_sel), .rx_bit(rx_bit),
        .tx_bit(tx_bit), .fine_tap(fine_tap), .bit_cnt(bit_cnt),
        .err_cnt(err_cnt), .locked(locked)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] mask_of(logic [1:0] o);
        return o == 2'b00 ? 24'h0000B8 : o == 2'b01 ? 24'h00B400 : 24'hE10000;
    endfunction

    function automatic int idx_of(logic [1:0] o);
        return o == 2'b00 ? 7 : o == 2'b01 ? 15 : 23;
    endfunction

    // Compare n output bits with the model, starting from the all-ones seed.
    task automatic seq_match(string req, logic [1:0] o, int n);
        logic [23:0] m = '1;
        int miss = 0;
        for (int i = 0; i < n; i++) begin
            if (tx_bit !== m[idx_of(o)]) miss++;
            m = {m[22:0], ^(m & mask_of(o))};
            tick(1);
        end
        check(req, miss, 0);
    endtask

    task automatic stop_run();
        run = 1'b0;
        tick(2);
    endtask

    task automatic start_run(logic [1:0] o, int dly);
        ord_sel = o; coarse_sel = 5'(dly); d = dly; run = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        check("R2 idle tx", tx_bit, 0);
        check("R2 idle bits", bit_cnt, 0);
        check("R9 lock reset", locked, 0);
        check("R10 tap reset", fine_tap, 0);
    endtask

    task automatic t_orders();
        for (int o = 0; o < 4; o++) begin
            stop_run();
            start_run(2'(o), 0);
            seq_match("R1 sequence", 2'(o), 300);
        end
    endtask

    task automatic t_lock_count();
        stop_run();
        start_run(2'b10, 5);
        check("R11 start clears", bit_cnt, 0);
        tick(63);
        check("R9 not yet locked", locked, 0);
        tick(1);
        check("R9 locked at 64", locked, 1);
        check("R4 bit count", bit_cnt, 64);
        check("R3 aligned no errors", err_cnt, 0);
    endtask

    task automatic t_inject();
        logic [47:0] b = bit_cnt;
        inj = 1'b1; tick(1); inj = 1'b0;
        check("R4 one error", err_cnt, 1);
        check("R9 lock drop", locked, 0);
        check("R4 bits keep counting", bit_cnt, b + 1);
    endtask

    task automatic t_misalign();
        stop_run();
        start_run(2'b01, 5);
        d = 7;
        tick(100);
        check("R3 misaligned errors", err_cnt > 0, 1);
        check("R3 misaligned no lock", locked, 0);
    endtask

    task automatic t_saturate();
        stop_run();
        start_run(2'b00, 3);
        inj = 1'b1; tick(300); inj = 1'b0;
        check("R5 saturated", err_cnt, 255);
        check("R5 bits", bit_cnt, 300);
    endtask

    task automatic t_clear();
        clr = 1'b1; tick(1);
        check("R6 bits cleared", bit_cnt, 0);
        check("R6 errs cleared", err_cnt, 0);
        clr = 1'b0; tick(1);
        check("R6 count resumes", bit_cnt, 1);
    endtask

    task automatic t_coarse_change();
        tick(70);
        coarse_sel = 5'd9; d = 9; tick(1);
        check("R7 clear on delay change", bit_cnt, 0);
        check("R7 lock cleared", locked, 0);
        tick(64);
        check("R7 relock", locked, 1);
        check("R3 delay 9 clean", err_cnt, 0);
    endtask

    task automatic t_order_change();
        ord_sel = 2'b01; tick(1);
        check("R8 clear on order change", bit_cnt, 0);
        check("R8 lock cleared", locked, 0);
        seq_match("R8 reseeded", 2'b01, 40);
    endtask

    task automatic t_fine();
        logic [47:0] b = bit_cnt;
        fine_sel = 6'h2A; tick(1);
        check("R10 tap follows", fine_tap, 6'h2A);
        check("R10 counting unaffected", bit_cnt, b + 1);
        check("R10 no errors", err_cnt, 0);
    endtask

    task automatic t_stop_restart();
        logic [47:0] b;
        run = 1'b0; tick(1);
        b = bit_cnt;
        check("R2 stop quiet", tx_bit, 0);
        tick(10);
        check("R2 bits hold", bit_cnt, b);
        check("R2 tx stays low", tx_bit, 0);
        check("R11 wide counter", $bits(bit_cnt), 48);
        run = 1'b1; tick(1);
        check("R11 restart clears", bit_cnt, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_orders();
        t_lock_count();
        t_inject();
        t_misalign();
        t_saturate();
        t_clear();
        t_coarse_change();
        t_order_change();
        t_fine();
        t_stop_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule